// File: doc/BRIEF.md
# Toggle-Chain Up/Down Counter

A three-bit synchronous counter built from toggle flip-flops, not from an adder and a holding register. Bit 0 toggles on every clock edge. Each higher bit toggles only when the enable chain below it is active. That chain is the AND of the lower bits, where each lower bit passes through a 2:1 polarity multiplexer. The multiplexer picks either the true output or the complemented output of the bit.

A single direction input drives every multiplexer. The true outputs give an incrementing count and the complemented outputs give a decrementing count. The direction is sampled on the same edge as the flip-flops, so a change acts on the state held at that edge. The three toggle enables come out as outputs so the carry chain can be observed directly.

Top module: `tcc_counter`

## Requirements
- R1: An active-high synchronous reset sets all three count bits to 0 on the next rising edge, whatever the direction input is.
- R2: Toggle enable bit 0 is always 1, so count bit 0 inverts on every edge that is not a reset edge.
- R3: Toggle enable bit 1 equals count bit 0 when the direction input is 0 (up). It equals the inverse of count bit 0 when the direction input is 1 (down).
- R4: Toggle enable bit 2 is the AND of the polarity-selected count bits 0 and 1. The same direction encoding as in R3 applies.
- R5: On each non-reset edge, every count bit whose toggle enable is 1 inverts, and every count bit whose enable is 0 keeps its value.
- R6: With the direction input at 0, the count steps 0,1,2,…,7 and then wraps from 7 to 0.
- R7: With the direction input at 1, the count steps down by one per edge and wraps from 0 to 7. For example, 7 goes to 6.
- R8: A change of the direction input acts on the very next edge, with no added latency. This includes a change while the count is at 7 or at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_dn | input | 1 | Direction select: 0 counts up, 1 counts down |
| count | output | 3 | Current count value |
| tgl_en | output | 3 | Toggle enable of each flip-flop, bit i for count bit i |

## Verification
A wrong bit in the flip-flop state shows on `count` in the same cycle. Because every enable is derived from that state, the error also changes `tgl_en` at once. It then pushes the counter one step off the up/down reference on every following edge until a reset. A polarity or chain fault usually stays hidden until a carry or borrow is needed: a wrong bit 1 appears within two edges, and a wrong bit 2 appears within four. For that reason the enables are compared combinationally on every cycle, across both directions and at direction changes on 7 and 0.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   localparam int TCC_BITS = 3;

   typedef enum logic {
      TCC_UP   = 1'b0,
      TCC_DOWN = 1'b1
   } tcc_dir_e;
endpackage

// File: rtl/tcc_tflop.sv
// Single toggle flip-flop with synchronous reset.
module tcc_tflop #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic t,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)
         q <= RST_VAL;
      else if (t)
         q <= ~q;
   end
endmodule

// File: rtl/tcc_polarity_mux.sv
// 2:1 choice between the true and complemented flip-flop output.
module tcc_polarity_mux (
   input  logic q,
   input  logic dn,
   output logic y
);
   always_comb begin
      y = (dn == tcc_pkg::TCC_DOWN) ? ~q : q;
   end
endmodule

// File: rtl/tcc_enable_chain.sv
// Ripple AND chain: stage 0 is tied high, stage i ANDs the selected lower bits.
module tcc_enable_chain #(
   parameter int W = tcc_pkg::TCC_BITS
) (
   input  logic [W-2:0] sel,
   output logic [W-1:0] en
);
   if (W < 2) begin : g_bad_w
      $error("tcc_enable_chain: W must be at least 2");
   end

   assign en[0] = 1'b1;
   for (genvar i = 1; i < W; i++) begin : g_stage
      assign en[i] = en[i-1] & sel[i-1];
   end
endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
   parameter int WIDTH = tcc_pkg::TCC_BITS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dir_dn,
   output logic [WIDTH-1:0] count,
   output logic [WIDTH-1:0] tgl_en
);
   localparam int NSEL = WIDTH - 1;

   if (WIDTH != 3) begin : g_width_check
      $error("tcc_counter: only a 3-bit count is supported");
   end

   logic [NSEL-1:0] sel_q;

   for (genvar b = 0; b < NSEL; b++) begin : g_mux
      tcc_polarity_mux u_mux (
         .q  (count[b]),
         .dn (dir_dn),
         .y  (sel_q[b])
      );
   end

   tcc_enable_chain #(.W(WIDTH)) u_chain (
      .sel (sel_q),
      .en  (tgl_en)
   );

   for (genvar b = 0; b < WIDTH; b++) begin : g_ff
      tcc_tflop #(.RST_VAL(1'b0)) u_ff (
         .clk (clk),
         .rst (rst),
         .t   (tgl_en[b]),
         .q   (count[b])
      );
   end
endmodule

// File: rtl/tcc_counter_chk.sv
module tcc_counter_chk (
   input logic       clk,
   input logic       rst,
   input logic       dir_dn,
   input logic [2:0] count,
   input logic [2:0] tgl_en
);
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (rst) armed <= 1'b1;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      armed && $past(rst) |-> count == 3'd0); // R1

   AST_LSB_FLIPS: assert property (@(posedge clk) disable iff (rst)
      armed && !$past(rst) |-> count[0] != $past(count[0])); // R2

   AST_TOGGLE_RULE: assert property (@(posedge clk) disable iff (rst)
      armed && !$past(rst) |-> count == ($past(count) ^ $past(tgl_en))); // R5

   AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
      armed && !$past(rst) && !$past(dir_dn) |-> count == 3'($past(count) + 3'd1)); // R6

   AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
      armed && !$past(rst) && $past(dir_dn) |-> count == 3'($past(count) - 3'd1)); // R7
endmodule

bind tcc_counter tcc_counter_chk u_chk (
   .clk    (clk),
   .rst    (rst),
   .dir_dn (dir_dn),
   .count  (count),
   .tgl_en (tgl_en)
);

// File: tb/tcc_counter_test.sv
`timescale 1ns/1ps
module tcc_counter_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       dir_dn = 1'b0;
   logic [2:0] count;
   logic [2:0] tgl_en;

   int tests = 0;
   int fails = 0;
   int ref_cnt = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tcc_counter uut (
      .clk    (clk),
      .rst    (rst),
      .dir_dn (dir_dn),
      .count  (count),
      .tgl_en (tgl_en)
   );

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_en(input int c, input bit dn);
      int s0, s1;
      s0 = dn ? ((c & 1) ^ 1) : (c & 1);
      s1 = dn ? (((c >> 1) & 1) ^ 1) : ((c >> 1) & 1);
      return 1 | (s0 << 1) | ((s0 & s1) << 2);
   endfunction

   // At negedge: compare outputs with the model, then apply new inputs and advance the model.
   task automatic step(input bit r, input bit dn, input string tag);
      @(negedge clk);
      check({tag, " count"}, int'(count), ref_cnt);
      check("R2/R3/R4 tgl_en", int'(tgl_en), exp_en(ref_cnt, dir_dn));
      rst = r;
      dir_dn = dn;
      if (r) ref_cnt = 0;
      else if (dn) ref_cnt = (ref_cnt + 7) % 8;
      else ref_cnt = (ref_cnt + 1) % 8;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      ref_cnt = 0;
      step(1'b1, 1'b0, "R1");
      step(1'b1, 1'b1, "R1");
      step(1'b0, 1'b0, "R1 reset value");
      // R6: full up cycle with wrap 7 -> 0
      for (int k = 0; k < 10; k++) step(1'b0, 1'b0, "R6 up");
      // run up to 7, then reverse at 7 (R8)
      while (ref_cnt != 7) step(1'b0, 1'b0, "R6 up");
      step(1'b0, 1'b1, "R8 reverse at 7");
      // R7: full down cycle with wrap 0 -> 7
      for (int k = 0; k < 10; k++) step(1'b0, 1'b1, "R7 down");
      while (ref_cnt != 0) step(1'b0, 1'b1, "R7 down");
      step(1'b0, 1'b0, "R8 reverse at 0");
      step(1'b0, 1'b0, "R8 up after 0");
      // R1: reset wins while counting down
      step(1'b1, 1'b1, "R1 priority");
      step(1'b0, 1'b1, "R1 priority");
      // random directions and occasional reset (R5)
      for (int k = 0; k < 400; k++) begin
         step(($urandom_range(0, 49) == 0), 1'($urandom_range(0, 1)), "R5 random");
      end
      for (int k = 0; k < 40; k++) step(1'b0, k[0], "R8 alternate");
      step(1'b0, 1'b0, "R6 final");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule